// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR-style flash. It watches bus write cycles: an address, a data word, an active-low write strobe and a byte/word bus-mode select. An instruction opens with two unlock writes. A command byte follows on the third write. From these the decoder recognises four instructions: program, auto-select entry, full-array erase and block erase. The storage array, erase timing and status-bit generation sit elsewhere and react to the decoder's outputs.

Each write takes its address when the strobe falls and its data when the strobe rises. The write is acted on in the clock cycle in which the rise is seen. A launched operation appears as a single-cycle start pulse, with the captured address (and, for programming, the data) held steady on dedicated outputs. A two-bit read-mode output tells the read path what to return: array data, identification data or status. Any malformed sequence drops the decoder back to the array read mode. While the array reports itself busy, only the reset and suspend codes have any effect.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `read_mode` is 0 (array) and every start pulse and `suspend_req` are low.
- R2: The unlock pair is data AAh then 55h, with the command byte carried in data bits [7:0]. In word mode (`byte_mode`=0) the pair's addresses are 5555h then 2AAAh. In byte mode they are AAAAh then 5555h. The third (command) write must use the first unlock address.
- R3: Unlock, then A0h, then a fourth write makes `prog_start` high for one cycle, in the cycle after the clock edge that sees the strobe rise. `prog_addr` then equals the address present when the strobe fell, and `prog_data` the data present when it rose, even if that data is F0h. `read_mode` becomes 2 (status).
- R4: Unlock, then 90h, sets `read_mode` to 1 (auto-select) and raises no pulse.
- R5: Unlock, 80h, a second unlock pair, then 10h at the first unlock address gives one `chip_erase_start` pulse and sets `read_mode` to 2.
- R6: Unlock, 80h, a second unlock pair, then 30h at any address gives one `blk_erase_start` pulse with `blk_addr` equal to that write's address, and sets `read_mode` to 2.
- R7: A wrong unlock data or address, an unknown command byte, a wrong command address, or a confirm other than 30h (or other than 10h at the first unlock address) raises no pulse and sets `read_mode` to 0.
- R8: A write of F0h outside the program data slot returns `read_mode` to 0 from auto-select or status.
- R9: While `busy` is high, a write of F0h sets `read_mode` to 0 and restarts the sequence. A write of B0h gives one `suspend_req` pulse. Every other write raises no pulse, leaves `read_mode` unchanged and does not advance the sequence.
- R10: At most one of `prog_start`, `chip_erase_start` and `blk_erase_start` is high in any cycle. Each pulse, including `suspend_req`, lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Write strobe, active low, synchronous to clk |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data; command byte in bits [7:0] |
| byte_mode | input | 1 | 1 selects the byte-wide unlock addresses |
| busy | input | 1 | Array operation in progress |
| prog_start | output | 1 | One-cycle program launch |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | DATA_W | Program data |
| chip_erase_start | output | 1 | One-cycle full-array erase launch |
| blk_erase_start | output | 1 | One-cycle block erase launch |
| blk_addr | output | ADDR_W | Address of the block to erase |
| suspend_req | output | 1 | One-cycle suspend request |
| read_mode | output | 2 | 0 array, 1 auto-select, 2 status |

## Verification
The command byte after a correct unlock pair is swept over all 256 values in both bus modes. This separates the three accepted commands from every rejected one and shows that only A0h and 80h leave a sequence pending. The confirm byte after a full erase preamble is swept the same way, so 10h and 30h are told apart from each other and from every abort. Directed sequences change the address between the strobe edges to show which edge captures what, and swap the two modes' unlock addresses. They also interleave busy-time writes with a half-finished sequence, which shows that ignored writes neither advance nor break it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNLK1,
        SQ_UNLK2,
        SQ_PROG,
        SQ_EU1,
        SQ_EU2,
        SQ_CONF
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY   = 2'd0,
        RM_AUTOSEL = 2'd1,
        RM_STATUS  = 2'd2
    } read_mode_t;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_AUTOSEL = 8'h90;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_BLOCK   = 8'h30;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;

endpackage

// File: rtl/fcd_wr_strobe.sv
module fcd_wr_strobe #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              evt_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic              wr_n;
        logic [ADDR_W-1:0] addr;
    } strb_reg_t;

    strb_reg_t r_d, r_q;
    logic      fall;

    always_comb begin
        r_d      = r_q;
        r_d.wr_n = wr_n_i;
        fall     = r_q.wr_n & ~wr_n_i;
        if (fall) begin
            r_d.addr = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.wr_n <= 1'b1;
            r_q.addr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Rising strobe completes a write cycle
    assign evt_o  = ~r_q.wr_n & wr_n_i;
    assign addr_o = r_q.addr;

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.wr_n && !wr_n_i) |=> $stable(r_q.addr));

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter int              DATA_W      = 16,
    parameter logic [ADDR_W-1:0] WORD_KEY_A = 'h5555,
    parameter logic [ADDR_W-1:0] WORD_KEY_B = 'h2AAA,
    parameter logic [ADDR_W-1:0] BYTE_KEY_A = 'hAAAA,
    parameter logic [ADDR_W-1:0] BYTE_KEY_B = 'h5555
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              byte_mode_i,
    input  logic              busy_i,
    output logic              prog_start_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [DATA_W-1:0] prog_data_o,
    output logic              chip_erase_o,
    output logic              blk_erase_o,
    output logic [ADDR_W-1:0] blk_addr_o,
    output logic              suspend_o,
    output read_mode_t        read_mode_o
);

    typedef struct packed {
        seq_state_t        st;
        read_mode_t        rm;
        logic              prog;
        logic              chip;
        logic              blk;
        logic              susp;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
        logic [ADDR_W-1:0] baddr;
    } seq_reg_t;

    seq_reg_t          r_d, r_q;
    logic [7:0]        cmd;
    logic [ADDR_W-1:0] key_a;
    logic [ADDR_W-1:0] key_b;
    logic              at_a;
    logic              at_b;

    assign cmd   = data_i[7:0];
    assign key_a = byte_mode_i ? BYTE_KEY_A : WORD_KEY_A;
    assign key_b = byte_mode_i ? BYTE_KEY_B : WORD_KEY_B;
    assign at_a  = (addr_i == key_a);
    assign at_b  = (addr_i == key_b);

    always_comb begin
        r_d      = r_q;
        r_d.prog = 1'b0;
        r_d.chip = 1'b0;
        r_d.blk  = 1'b0;
        r_d.susp = 1'b0;
        if (evt_i) begin
            if (busy_i) begin
                if (cmd == CMD_RESET) begin
                    r_d.st = SQ_IDLE;
                    r_d.rm = RM_ARRAY;
                end else if (cmd == CMD_SUSPEND) begin
                    r_d.susp = 1'b1;
                end
            end else begin
                // default outcome of any write: abort to array read
                r_d.st = SQ_IDLE;
                r_d.rm = RM_ARRAY;
                unique case (r_q.st)
                    SQ_IDLE: begin
                        if (at_a && cmd == CMD_KEY_A) begin
                            r_d.st = SQ_UNLK1;
                            r_d.rm = r_q.rm;
                        end
                    end
                    SQ_UNLK1: begin
                        if (at_b && cmd == CMD_KEY_B) begin
                            r_d.st = SQ_UNLK2;
                            r_d.rm = r_q.rm;
                        end
                    end
                    SQ_UNLK2: begin
                        if (at_a) begin
                            if (cmd == CMD_PROG) begin
                                r_d.st = SQ_PROG;
                                r_d.rm = r_q.rm;
                            end else if (cmd == CMD_AUTOSEL) begin
                                r_d.rm = RM_AUTOSEL;
                            end else if (cmd == CMD_ERASE) begin
                                r_d.st = SQ_EU1;
                                r_d.rm = r_q.rm;
                            end
                        end
                    end
                    SQ_PROG: begin
                        r_d.prog  = 1'b1;
                        r_d.paddr = addr_i;
                        r_d.pdata = data_i;
                        r_d.rm    = RM_STATUS;
                    end
                    SQ_EU1: begin
                        if (at_a && cmd == CMD_KEY_A) begin
                            r_d.st = SQ_EU2;
                            r_d.rm = r_q.rm;
                        end
                    end
                    SQ_EU2: begin
                        if (at_b && cmd == CMD_KEY_B) begin
                            r_d.st = SQ_CONF;
                            r_d.rm = r_q.rm;
                        end
                    end
                    SQ_CONF: begin
                        if (cmd == CMD_CHIP && at_a) begin
                            r_d.chip = 1'b1;
                            r_d.rm   = RM_STATUS;
                        end else if (cmd == CMD_BLOCK) begin
                            r_d.blk   = 1'b1;
                            r_d.baddr = addr_i;
                            r_d.rm    = RM_STATUS;
                        end
                    end
                    default: begin
                        r_d.st = SQ_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= SQ_IDLE;
            r_q.rm    <= RM_ARRAY;
            r_q.prog  <= 1'b0;
            r_q.chip  <= 1'b0;
            r_q.blk   <= 1'b0;
            r_q.susp  <= 1'b0;
            r_q.paddr <= '0;
            r_q.pdata <= '0;
            r_q.baddr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign prog_start_o = r_q.prog;
    assign prog_addr_o  = r_q.paddr;
    assign prog_data_o  = r_q.pdata;
    assign chip_erase_o = r_q.chip;
    assign blk_erase_o  = r_q.blk;
    assign blk_addr_o   = r_q.baddr;
    assign suspend_o    = r_q.susp;
    assign read_mode_o  = r_q.rm;

    // R10
    start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.prog, r_q.chip, r_q.blk}));

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.prog || r_q.chip || r_q.blk || r_q.susp)
        |=> !(r_q.prog || r_q.chip || r_q.blk || r_q.susp));

    // R3
    prog_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.prog || r_q.chip || r_q.blk) |-> (r_q.rm == RM_STATUS));

    // R7
    launch_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.prog || r_q.chip || r_q.blk || r_q.susp) |-> $past(evt_i));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && busy_i && cmd != CMD_RESET && cmd != CMD_SUSPEND)
        |=> (!r_q.prog && !r_q.chip && !r_q.blk && $stable(r_q.rm) && $stable(r_q.st)));

    // R4
    mode_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> $stable(r_q.rm));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter int              DATA_W      = 16,
    parameter logic [ADDR_W-1:0] WORD_KEY_A = 'h5555,
    parameter logic [ADDR_W-1:0] WORD_KEY_B = 'h2AAA,
    parameter logic [ADDR_W-1:0] BYTE_KEY_A = 'hAAAA,
    parameter logic [ADDR_W-1:0] BYTE_KEY_B = 'h5555
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              byte_mode,
    input  logic              busy,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              chip_erase_start,
    output logic              blk_erase_start,
    output logic [ADDR_W-1:0] blk_addr,
    output logic              suspend_req,
    output logic [1:0]        read_mode
);

    logic              wr_evt;
    logic [ADDR_W-1:0] wr_addr;
    read_mode_t        rm;

    fcd_wr_strobe #(
        .ADDR_W (ADDR_W)
    ) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n_i (wr_n),
        .addr_i (bus_addr),
        .evt_o  (wr_evt),
        .addr_o (wr_addr)
    );

    fcd_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .WORD_KEY_A (WORD_KEY_A),
        .WORD_KEY_B (WORD_KEY_B),
        .BYTE_KEY_A (BYTE_KEY_A),
        .BYTE_KEY_B (BYTE_KEY_B)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (wr_evt),
        .addr_i       (wr_addr),
        .data_i       (bus_data),
        .byte_mode_i  (byte_mode),
        .busy_i       (busy),
        .prog_start_o (prog_start),
        .prog_addr_o  (prog_addr),
        .prog_data_o  (prog_data),
        .chip_erase_o (chip_erase_start),
        .blk_erase_o  (blk_erase_start),
        .blk_addr_o   (blk_addr),
        .suspend_o    (suspend_req),
        .read_mode_o  (rm)
    );

    assign read_mode = rm;

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        byte_mode = 1'b0;
    logic        busy = 1'b0;
    logic        prog_start;
    logic [15:0] prog_addr;
    logic [15:0] prog_data;
    logic        chip_erase_start;
    logic        blk_erase_start;
    logic [15:0] blk_addr;
    logic        suspend_req;
    logic [1:0]  read_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic s_prog, s_chip, s_blk, s_susp;

    always #2 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_n             (wr_n),
        .bus_addr         (bus_addr),
        .bus_data         (bus_data),
        .byte_mode        (byte_mode),
        .busy             (busy),
        .prog_start       (prog_start),
        .prog_addr        (prog_addr),
        .prog_data        (prog_data),
        .chip_erase_start (chip_erase_start),
        .blk_erase_start  (blk_erase_start),
        .blk_addr         (blk_addr),
        .suspend_req      (suspend_req),
        .read_mode        (read_mode)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] key_a(input logic bm);
        return bm ? 16'hAAAA : 16'h5555;
    endfunction

    function automatic logic [15:0] key_b(input logic bm);
        return bm ? 16'h5555 : 16'h2AAA;
    endfunction

    // One bus write: address valid at the falling strobe, then replaced by
    // its complement; data valid only at the rising strobe.
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_n = 1'b0; bus_addr = a; bus_data = ~d;
        @(negedge clk);
        bus_addr = ~a; bus_data = d;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        s_prog = prog_start; s_chip = chip_erase_start;
        s_blk = blk_erase_start; s_susp = suspend_req;
        @(negedge clk);
        // R10 pulses last one cycle
        chk(!(prog_start || chip_erase_start || blk_erase_start || suspend_req),
            "R10", "pulse width", {28'd0, prog_start, chip_erase_start, blk_erase_start, suspend_req}, 0);
    endtask

    task automatic unlock(input logic bm);
        wr(key_a(bm), 16'h00AA);
        wr(key_b(bm), 16'h0055);
    endtask

    task automatic no_pulse(input string rq);
        chk(!(s_prog || s_chip || s_blk || s_susp), rq, "unexpected pulse",
            {28'd0, s_prog, s_chip, s_blk, s_susp}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(read_mode == 2'd0, "R1", "read_mode", read_mode, 0);
        chk(!(prog_start || chip_erase_start || blk_erase_start || suspend_req), "R1", "pulses",
            {28'd0, prog_start, chip_erase_start, blk_erase_start, suspend_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R7 command byte sweep in both modes
        for (int m = 0; m < 2; m++) begin
            byte_mode = m[0];
            for (int c = 0; c < 256; c++) begin
                logic [1:0] exp_rm;
                wr(16'h0000, 16'h00F0);
                unlock(m[0]);
                wr(key_a(m[0]), {8'h5A, c[7:0]});
                no_pulse("R7");
                exp_rm = (c == 8'h90) ? 2'd1 : 2'd0;
                chk(read_mode == exp_rm, (c == 8'h90) ? "R4" : "R7", "cmd sweep mode", read_mode, exp_rm);
                if (c == 8'hA0) begin
                    wr(16'h1234 ^ c[15:0], 16'hC35A);
                    chk(s_prog == 1'b1, "R3", "prog pulse", s_prog, 1);
                    chk(prog_addr == (16'h1234 ^ c[15:0]), "R3", "prog_addr", prog_addr, 16'h1234 ^ c[15:0]);
                    chk(prog_data == 16'hC35A, "R3", "prog_data", prog_data, 16'hC35A);
                    chk(read_mode == 2'd2, "R3", "status mode", read_mode, 2);
                end
            end
        end

        // R5 R6 R7 confirm byte sweep in both modes
        for (int m = 0; m < 2; m++) begin
            byte_mode = m[0];
            for (int c = 0; c < 256; c++) begin
                wr(16'h0000, 16'h00F0);
                unlock(m[0]);
                wr(key_a(m[0]), 16'h0080);
                unlock(m[0]);
                wr(key_a(m[0]), {8'h00, c[7:0]});
                chk(s_chip == (c == 8'h10), "R5", "chip pulse", s_chip, c == 8'h10);
                chk(s_blk == (c == 8'h30), "R6", "blk pulse", s_blk, c == 8'h30);
                chk(!s_prog, "R10", "prog during erase", s_prog, 0);
                chk(read_mode == ((c == 8'h10 || c == 8'h30) ? 2'd2 : 2'd0),
                    "R7", "confirm mode", read_mode, (c == 8'h10 || c == 8'h30) ? 2 : 0);
                if (c == 8'h30)
                    chk(blk_addr == key_a(m[0]), "R6", "blk_addr", blk_addr, key_a(m[0]));
            end
        end

        // R6 block erase at an arbitrary address
        byte_mode = 1'b0;
        wr(16'h0000, 16'h00F0);
        unlock(1'b0); wr(16'h5555, 16'h0080); unlock(1'b0);
        wr(16'h7E01, 16'h0030);
        chk(s_blk && blk_addr == 16'h7E01, "R6", "block addr", blk_addr, 16'h7E01);

        // R7 chip confirm away from the command address aborts
        wr(16'h0000, 16'h00F0);
        unlock(1'b0); wr(16'h5555, 16'h0080); unlock(1'b0);
        wr(16'h1000, 16'h0010);
        no_pulse("R7");
        chk(read_mode == 2'd0, "R7", "chip confirm wrong addr", read_mode, 0);

        // R2 byte-mode addresses rejected in word mode
        wr(16'h5555, 16'h0090);
        wr(16'hAAAA, 16'h00AA); wr(16'h5555, 16'h0055); wr(16'hAAAA, 16'h0090);
        chk(read_mode == 2'd0, "R2", "byte keys in word mode", read_mode, 0);
        // R2 word-mode addresses rejected in byte mode
        byte_mode = 1'b1;
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
        chk(read_mode == 2'd0, "R2", "word keys in byte mode", read_mode, 0);
        // R7 wrong second unlock data
        byte_mode = 1'b0;
        unlock(1'b0); wr(16'h5555, 16'h0090);
        chk(read_mode == 2'd1, "R4", "autoselect entry", read_mode, 1);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0056); wr(16'h5555, 16'h00A0);
        wr(16'h0400, 16'h0001);
        no_pulse("R7");
        chk(read_mode == 2'd0, "R7", "bad unlock data", read_mode, 0);

        // R8 F0 leaves auto-select
        unlock(1'b0); wr(16'h5555, 16'h0090);
        wr(16'h0123, 16'h00F0);
        chk(read_mode == 2'd0, "R8", "reset from autoselect", read_mode, 0);

        // R3 F0 in the data slot is programmed
        unlock(1'b0); wr(16'h5555, 16'h00A0);
        wr(16'h0042, 16'h00F0);
        chk(s_prog && prog_data == 16'h00F0, "R3", "F0 as data", prog_data, 16'h00F0);
        chk(read_mode == 2'd2, "R3", "status after F0 data", read_mode, 2);
        // R8 F0 leaves status
        wr(16'h0000, 16'h00F0);
        chk(read_mode == 2'd0, "R8", "reset from status", read_mode, 0);

        // R9 busy: launch then ignored writes
        unlock(1'b0); wr(16'h5555, 16'h00A0); wr(16'h0010, 16'h0011);
        busy = 1'b1;
        unlock(1'b0); wr(16'h5555, 16'h00A0);
        wr(16'h0020, 16'h0022);
        no_pulse("R9");
        chk(read_mode == 2'd2, "R9", "busy ignores writes", read_mode, 2);
        chk(prog_addr == 16'h0010, "R9", "prog_addr held", prog_addr, 16'h0010);
        wr(16'h0000, 16'h00B0);
        chk(s_susp == 1'b1, "R9", "suspend pulse", s_susp, 1);
        chk(read_mode == 2'd2, "R9", "mode after suspend", read_mode, 2);
        wr(16'h0000, 16'h00F0);
        chk(read_mode == 2'd0, "R9", "reset while busy", read_mode, 0);
        // R9 busy write does not advance a half sequence
        busy = 1'b0;
        wr(16'h5555, 16'h00AA);
        busy = 1'b1;
        wr(16'h2AAA, 16'h0055);
        busy = 1'b0;
        wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0); wr(16'h0077, 16'h0099);
        chk(s_prog && prog_addr == 16'h0077, "R9", "sequence not advanced", prog_addr, 16'h0077);
        // R7 suspend code while idle is just a bad write
        wr(16'h0000, 16'h00B0);
        no_pulse("R7");
        chk(read_mode == 2'd0, "R7", "B0 not busy", read_mode, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule